// File: doc/BRIEF.md
# Flash Erase-Suspend Command Arbiter

This block sits in the command front end of a flash array. It takes byte-wide command writes and runs a long block erase, which is modelled as a countdown. The erase can be paused so that other work can be done, and it picks up again later from the count at which it stopped. While the erase is paused, the block accepts only a narrow set of commands. One of these is a program operation. That nested program must finish before the erase can be restarted, and the program can itself be paused and restarted.

The block reports progress through an 8-bit status byte and a ready pin. It also has a mode flag that says whether array reads return the status byte. Software starts an erase and polls the status byte. It issues a suspend and waits for the suspended bit, then does its other work and issues a resume.

Top module: `eraseSuspArb`

## Requirements
- R1: After reset the status byte is 0x80 and the ready pin is 1. The status-read mode flag is 0 and the erase remainder is 0. Status bit 7 means ready, bit 6 erase suspended, bit 5 and bit 4 invalid sequence, and bit 2 program suspended; bits 3, 1 and 0 always read 0.
- R2: The erase command 0x20, written while idle, loads the erase remainder with ERASE_LEN. The remainder then falls by one each cycle. Bit 7 and the ready pin stay 0 until the remainder reaches 0, which happens ERASE_LEN cycles after the command.
- R3: The suspend command 0xB0, written during a running erase, sets bit 6 and bit 7 exactly SUSP_LAT cycles later. The erase keeps counting until that point and then holds its remainder.
- R4: While the erase is held, a command outside the set {0x70 read status, 0x50 clear status, 0x98 query, 0xB8 configure, 0xD0 resume, 0x40 program} sets bits 5 and 4. It leaves bits 6 and 7 and the remainder unchanged.
- R5: The clear status command 0x50 clears bits 5 and 4 when it is written in the idle, erase-held or program-held state.
- R6: The program command 0x40, written while the erase is held, clears bit 7 for PROG_LEN cycles and keeps bit 6 set. The block then returns to the held erase with its remainder unchanged.
- R7: A resume 0xD0 written while a nested program is running has no effect. When the program ends, the erase is still held.
- R8: A resume 0xD0 written while the erase is held clears bits 6 and 7 and the ready pin on the next cycle, and sets the status-read mode flag. The erase then continues counting down from the held remainder.
- R9: A suspend 0xB0 written during a program sets bit 2 and bit 7 on the next cycle and freezes the program's progress. A resume 0xD0 continues the program, so that the program is busy for PROG_LEN counted cycles in total.
- R10: While an erase or program is running, every command other than suspend 0xB0 and read status 0x70 is ignored. In particular, a clear status written during that time leaves bits 5 and 4 as they were.
- R11: The commands 0x20, 0x40, 0x70, an accepted 0xB0 and an accepted 0xD0 set the status-read mode flag. An accepted 0x98, 0xB8 or 0xFF clears it.
- R12: If the erase remainder runs out before the suspend latency expires, the block goes idle with bit 7 set and bit 6 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command write strobe, one cycle per command |
| cmdCode | input | 8 | Command byte |
| statusReg | output | 8 | Status byte |
| stsPin | output | 1 | Ready pin: 1 when ready, 0 while an operation runs |
| readsStatus | output | 1 | Array reads return the status byte when 1 |
| eraseLeft | output | $clog2(ERASE_LEN+1) | Remaining erase count |

## Verification
Seeded random command streams are compared, cycle by cycle, against a reference model kept in the bench. These streams mix the nine defined codes with arbitrary bytes. They reach collisions that directed tests seldom hit, such as a suspend in the same cycle as completion, or illegal bytes while held. The directed sequences each target one corner case. One walks a full suspend, nested program, blocked resume and real resume, and so separates a frozen remainder from one that keeps counting. Another suspends a program and counts its total busy cycles, which separates a program that truly froze from one that kept running. A late suspend shows that completion takes priority over the pause.

// File: rtl/eraseSuspPkg.sv
package eraseSuspPkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ERASE_RUN, ST_ERASE_PAUSE, ST_ERASE_HELD, ST_PROG_RUN, ST_PROG_HELD
  } arbState_t;

  localparam logic [7:0] OP_ERASE   = 8'h20;
  localparam logic [7:0] OP_PROG    = 8'h40;
  localparam logic [7:0] OP_SUSPEND = 8'hB0;
  localparam logic [7:0] OP_RESUME  = 8'hD0;
  localparam logic [7:0] OP_RDSTAT  = 8'h70;
  localparam logic [7:0] OP_CLRSTAT = 8'h50;
  localparam logic [7:0] OP_QUERY   = 8'h98;
  localparam logic [7:0] OP_CONFIG  = 8'hB8;
  localparam logic [7:0] OP_RDARRAY = 8'hFF;

  typedef struct packed {
    logic loadErase;
    logic runErase;
    logic loadProg;
    logic runProg;
    logic loadSusp;
    logic runSusp;
    logic setErr;
    logic clrErr;
  } dpStrobe_t;

  function automatic logic heldLegal(input logic [7:0] code);
    return (code == OP_RESUME) || (code == OP_PROG) || (code == OP_RDSTAT) ||
           (code == OP_CLRSTAT) || (code == OP_QUERY) || (code == OP_CONFIG);
  endfunction

endpackage

// File: rtl/downCounter.sv
module downCounter #(
  parameter int W = 8,
  parameter int INIT = 100
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         load,
  input  logic         run,
  output logic [W-1:0] count,
  output logic         last
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              count <= '0;
    else if (load)          count <= W'(INIT);
    else if (run && count != '0) count <= count - 1'b1;
  end

  assign last = (count == W'(1));

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    count <= W'(INIT));
endmodule

// File: rtl/eraseSuspDp.sv
module eraseSuspDp
  import eraseSuspPkg::*;
#(
  parameter int ERASE_LEN = 400,
  parameter int PROG_LEN = 24,
  parameter int SUSP_LAT = 5,
  localparam int EW = $clog2(ERASE_LEN + 1),
  localparam int PW = $clog2(PROG_LEN + 1),
  localparam int SW = $clog2(SUSP_LAT + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobe_t     strobe,
  output logic [EW-1:0] eraseLeft,
  output logic          eraseDone,
  output logic          progDone,
  output logic          suspDone,
  output logic [1:0]    errFlags
);
  logic [PW-1:0] progLeft;
  logic [SW-1:0] suspLeft;

  downCounter #(.W(EW), .INIT(ERASE_LEN)) eraseCtr (
    .clk(clk), .rstN(rstN), .load(strobe.loadErase), .run(strobe.runErase),
    .count(eraseLeft), .last(eraseDone));

  downCounter #(.W(PW), .INIT(PROG_LEN)) progCtr (
    .clk(clk), .rstN(rstN), .load(strobe.loadProg), .run(strobe.runProg),
    .count(progLeft), .last(progDone));

  downCounter #(.W(SW), .INIT(SUSP_LAT)) suspCtr (
    .clk(clk), .rstN(rstN), .load(strobe.loadSusp), .run(strobe.runSusp),
    .count(suspLeft), .last(suspDone));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             errFlags <= 2'b00;
    else if (strobe.setErr) errFlags <= 2'b11;
    else if (strobe.clrErr) errFlags <= 2'b00;
  end
endmodule

// File: rtl/eraseSuspCtrl.sv
module eraseSuspCtrl
  import eraseSuspPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [7:0] cmdCode,
  input  logic       eraseDone,
  input  logic       progDone,
  input  logic       suspDone,
  output dpStrobe_t  strobe,
  output arbState_t  curState,
  output logic       nestedProg,
  output logic       readsStatus
);
  arbState_t nextState;
  logic nextNested, nextRs;

  always_comb begin
    nextState  = curState;
    nextNested = nestedProg;
    nextRs     = readsStatus;
    strobe     = '0;
    case (curState)
      ST_IDLE: if (cmdValid) begin
        case (cmdCode)
          OP_ERASE:   begin nextState = ST_ERASE_RUN; strobe.loadErase = 1'b1; nextRs = 1'b1; end
          OP_PROG:    begin nextState = ST_PROG_RUN; strobe.loadProg = 1'b1; nextRs = 1'b1; nextNested = 1'b0; end
          OP_RDSTAT:  nextRs = 1'b1;
          OP_CLRSTAT: strobe.clrErr = 1'b1;
          OP_QUERY, OP_CONFIG, OP_RDARRAY: nextRs = 1'b0;
          default: ;
        endcase
      end
      ST_ERASE_RUN: begin
        strobe.runErase = 1'b1;
        if (eraseDone) nextState = ST_IDLE;
        else if (cmdValid && cmdCode == OP_SUSPEND) begin
          nextState = ST_ERASE_PAUSE; strobe.loadSusp = 1'b1; nextRs = 1'b1;
        end else if (cmdValid && cmdCode == OP_RDSTAT) nextRs = 1'b1;
      end
      ST_ERASE_PAUSE: begin
        strobe.runErase = 1'b1;
        strobe.runSusp  = 1'b1;
        if (eraseDone)      nextState = ST_IDLE;
        else if (suspDone)  nextState = ST_ERASE_HELD;
        if (cmdValid && cmdCode == OP_RDSTAT) nextRs = 1'b1;
      end
      ST_ERASE_HELD: if (cmdValid) begin
        case (cmdCode)
          OP_RESUME:  begin nextState = ST_ERASE_RUN; nextRs = 1'b1; end
          OP_PROG:    begin nextState = ST_PROG_RUN; strobe.loadProg = 1'b1; nextNested = 1'b1; nextRs = 1'b1; end
          OP_RDSTAT:  nextRs = 1'b1;
          OP_CLRSTAT: strobe.clrErr = 1'b1;
          OP_QUERY, OP_CONFIG: nextRs = 1'b0;
          default:    strobe.setErr = 1'b1;
        endcase
      end
      ST_PROG_RUN: begin
        strobe.runProg = 1'b1;
        if (progDone) begin
          nextState  = nestedProg ? ST_ERASE_HELD : ST_IDLE;
          nextNested = 1'b0;
        end else if (cmdValid && cmdCode == OP_SUSPEND) begin
          nextState = ST_PROG_HELD; nextRs = 1'b1;
        end else if (cmdValid && cmdCode == OP_RDSTAT) nextRs = 1'b1;
      end
      ST_PROG_HELD: if (cmdValid) begin
        case (cmdCode)
          OP_RESUME:  begin nextState = ST_PROG_RUN; nextRs = 1'b1; end
          OP_RDSTAT:  nextRs = 1'b1;
          OP_CLRSTAT: strobe.clrErr = 1'b1;
          OP_QUERY, OP_CONFIG, OP_RDARRAY: nextRs = 1'b0;
          default: ;
        endcase
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curState    <= ST_IDLE;
      nestedProg  <= 1'b0;
      readsStatus <= 1'b0;
    end else begin
      curState    <= nextState;
      nestedProg  <= nextNested;
      readsStatus <= nextRs;
    end
  end

  // A resume during a nested program never restarts the erase (R7)
  assert_resume_blocked_R7: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_PROG_RUN && nestedProg && cmdValid && cmdCode == OP_RESUME)
    |=> (curState != ST_ERASE_RUN));
endmodule

// File: rtl/eraseSuspArb.sv
module eraseSuspArb
  import eraseSuspPkg::*;
#(
  parameter int ERASE_LEN = 400,
  parameter int PROG_LEN = 24,
  parameter int SUSP_LAT = 5,
  localparam int EW = $clog2(ERASE_LEN + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cmdValid,
  input  logic [7:0]    cmdCode,
  output logic [7:0]    statusReg,
  output logic          stsPin,
  output logic          readsStatus,
  output logic [EW-1:0] eraseLeft
);
  dpStrobe_t strobe;
  arbState_t curState;
  logic nestedProg, eraseDone, progDone, suspDone;
  logic [1:0] errFlags;
  logic srReady, srEraseSusp, srProgSusp;

  eraseSuspCtrl ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .eraseDone(eraseDone), .progDone(progDone), .suspDone(suspDone),
    .strobe(strobe), .curState(curState), .nestedProg(nestedProg),
    .readsStatus(readsStatus));

  eraseSuspDp #(.ERASE_LEN(ERASE_LEN), .PROG_LEN(PROG_LEN), .SUSP_LAT(SUSP_LAT)) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .eraseLeft(eraseLeft),
    .eraseDone(eraseDone), .progDone(progDone), .suspDone(suspDone),
    .errFlags(errFlags));

  assign srReady     = (curState == ST_IDLE) || (curState == ST_ERASE_HELD) ||
                       (curState == ST_PROG_HELD);
  assign srEraseSusp = (curState == ST_ERASE_HELD) || nestedProg;
  assign srProgSusp  = (curState == ST_PROG_HELD);
  assign statusReg   = {srReady, srEraseSusp, errFlags, 1'b0, srProgSusp, 2'b00};
  assign stsPin      = srReady;

  assert_illegal_flags_R4: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_ERASE_HELD && cmdValid && !heldLegal(cmdCode))
    |=> (statusReg[5:4] == 2'b11 && statusReg[7:6] == 2'b11 && $stable(eraseLeft)));

  assert_resume_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_ERASE_HELD && cmdValid && cmdCode == OP_RESUME)
    |=> (!statusReg[7] && !statusReg[6] && !stsPin && readsStatus));

  assert_held_frozen_R3: assert property (@(posedge clk) disable iff (!rstN)
    statusReg[6] |=> (!statusReg[6] || $stable(eraseLeft)));
endmodule

// File: tb/tb_eraseSuspArb.sv
module tb_eraseSuspArb;
  localparam int ELEN = 60;
  localparam int PLEN = 12;
  localparam int SLAT = 4;
  localparam int EW = $clog2(ELEN + 1);

  logic clk = 1'b0, rstN = 1'b0, cmdValid = 1'b0;
  logic [7:0] cmdCode = 8'h00;
  logic [7:0] statusReg;
  logic stsPin, readsStatus;
  logic [EW-1:0] eraseLeft;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model state: 0 idle,1 erase run,2 pause,3 erase held,4 prog run,5 prog held
  int mSt, mE, mP, mS, mErr;
  bit mNest, mRs;

  eraseSuspArb #(.ERASE_LEN(ELEN), .PROG_LEN(PLEN), .SUSP_LAT(SLAT)) dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .statusReg(statusReg), .stsPin(stsPin), .readsStatus(readsStatus),
    .eraseLeft(eraseLeft));

  always #10 clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int expStatus();
    bit r = (mSt == 0) || (mSt == 3) || (mSt == 5);
    bit s6 = (mSt == 3) || mNest;
    bit s2 = (mSt == 5);
    return {r, s6, 2'(mErr), 1'b0, s2, 2'b00};
  endfunction

  task automatic modelStep(bit v, logic [7:0] c);
    case (mSt)
      0: if (v) case (c)
           8'h20: begin mSt = 1; mE = ELEN; mRs = 1; end
           8'h40: begin mSt = 4; mP = PLEN; mRs = 1; mNest = 0; end
           8'h70: mRs = 1;
           8'h50: mErr = 0;
           8'h98, 8'hB8, 8'hFF: mRs = 0;
           default: ;
         endcase
      1: if (mE == 1) begin mE = 0; mSt = 0; end
         else begin
           mE--;
           if (v && c == 8'hB0) begin mSt = 2; mS = SLAT; mRs = 1; end
           else if (v && c == 8'h70) mRs = 1;
         end
      2: begin
           if (mE == 1) mSt = 0;
           else if (mS == 1) mSt = 3;
           if (mE > 0) mE--;
           if (mS > 0) mS--;
           if (v && c == 8'h70) mRs = 1;
         end
      3: if (v) case (c)
           8'hD0: begin mSt = 1; mRs = 1; end
           8'h40: begin mSt = 4; mP = PLEN; mNest = 1; mRs = 1; end
           8'h70: mRs = 1;
           8'h50: mErr = 0;
           8'h98, 8'hB8: mRs = 0;
           default: mErr = 3;
         endcase
      4: if (mP == 1) begin mP = 0; mSt = mNest ? 3 : 0; mNest = 0; end
         else begin
           mP--;
           if (v && c == 8'hB0) begin mSt = 5; mRs = 1; end
           else if (v && c == 8'h70) mRs = 1;
         end
      5: if (v) case (c)
           8'hD0: begin mSt = 4; mRs = 1; end
           8'h70: mRs = 1;
           8'h50: mErr = 0;
           8'h98, 8'hB8, 8'hFF: mRs = 0;
           default: ;
         endcase
      default: ;
    endcase
  endtask

  function automatic string stTag();
    case (mSt)
      0, 1: return "R2 model";
      2: return "R3 model";
      3: return "R4 model";
      4: return mNest ? "R6 model" : "R9 model";
      default: return "R9 model";
    endcase
  endfunction

  task automatic compareModel();
    chk(stTag(), statusReg, expStatus());
    chk({stTag(), " eraseLeft"}, eraseLeft, mE);
    chk("R11 model readsStatus", readsStatus, mRs);
    chk("R1 model stsPin", stsPin, expStatus() >> 7);
  endtask

  task automatic cycle(bit v, logic [7:0] c);
    cmdValid = v; cmdCode = c;
    modelStep(v, c);
    @(negedge clk);
    cmdValid = 1'b0;
    compareModel();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cycle(1'b0, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int held;
    mSt = 0; mE = 0; mP = 0; mS = 0; mErr = 0; mNest = 0; mRs = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 reset status", statusReg, 8'h80);
    chk("R1 reset pin", stsPin, 1);
    chk("R1 reset mode", readsStatus, 0);
    chk("R1 reset eraseLeft", eraseLeft, 0);

    // R2 plain erase
    cycle(1, 8'h20);
    chk("R2 loaded", eraseLeft, ELEN);
    chk("R2 busy pin", stsPin, 0);
    idle(ELEN - 1);
    chk("R2 not yet ready", statusReg[7], 0);
    idle(1);
    chk("R2 ready", statusReg[7], 1);
    chk("R2 drained", eraseLeft, 0);

    // R3 suspend latency and freeze
    cycle(1, 8'h20);
    idle(10);
    cycle(1, 8'hB0);
    idle(SLAT - 1);
    chk("R3 before latency", statusReg[6], 0);
    idle(1);
    chk("R3 suspended bits", statusReg[7:6], 2'b11);
    held = ELEN - 11 - SLAT;
    chk("R3 held remainder", eraseLeft, held);
    idle(20);
    chk("R3 frozen", eraseLeft, held);

    // R4 illegal commands while held, R5 clear
    cycle(1, 8'hFF);
    chk("R4 err bits", statusReg[5:4], 2'b11);
    chk("R4 still held", statusReg[7:6], 2'b11);
    cycle(1, 8'h20);
    chk("R4 no restart", eraseLeft, held);
    cycle(1, 8'h50);
    chk("R5 cleared", statusReg[5:4], 2'b00);
    cycle(1, 8'h98);
    chk("R11 query clears mode", readsStatus, 0);
    cycle(1, 8'h70);
    chk("R11 rdstat sets mode", readsStatus, 1);

    // R6 nested program
    cycle(1, 8'h40);
    chk("R6 busy", statusReg[7:6], 2'b01);
    idle(PLEN - 1);
    chk("R6 still busy", statusReg[7], 0);
    idle(1);
    chk("R6 back to held", statusReg[7:6], 2'b11);
    chk("R6 remainder kept", eraseLeft, held);

    // R7 resume blocked during nested program
    cycle(1, 8'h40);
    idle(2);
    cycle(1, 8'hD0);
    chk("R7 resume ignored", statusReg[7:6], 2'b01);
    idle(PLEN - 3);
    chk("R7 still held", statusReg[7:6], 2'b11);
    chk("R7 remainder kept", eraseLeft, held);

    // set errors for R10, then R8 resume
    cycle(1, 8'hB8);
    cycle(1, 8'hFF);
    cycle(1, 8'hD0);
    chk("R8 bits cleared", statusReg[7:6], 2'b00);
    chk("R8 pin low", stsPin, 0);
    chk("R8 mode", readsStatus, 1);
    chk("R8 continues from", eraseLeft, held);
    idle(1);
    chk("R8 counting", eraseLeft, held - 1);
    cycle(1, 8'h50);
    chk("R10 clear ignored", statusReg[5:4], 2'b11);
    cycle(1, 8'h98);
    chk("R10 query ignored", readsStatus, 1);
    cycle(1, 8'h40);
    chk("R10 prog ignored", eraseLeft, held - 4);
    idle(held - 4);
    chk("R8 finished", statusReg[7], 1);
    cycle(1, 8'h50);
    chk("R5 idle clear", statusReg[5:4], 2'b00);

    // R9 program suspend / resume
    cycle(1, 8'h40);
    idle(2);
    cycle(1, 8'hB0);
    chk("R9 suspended", statusReg, 8'h84);
    cycle(1, 8'h20);
    chk("R10 erase ignored in prog hold", statusReg, 8'h84);
    idle(9);
    cycle(1, 8'hD0);
    chk("R9 resumed busy", statusReg[7], 0);
    idle(PLEN - 4);
    chk("R9 not yet done", statusReg[7], 0);
    idle(1);
    chk("R9 done", statusReg, 8'h80);

    // R12 erase ends inside the suspend window
    cycle(1, 8'h20);
    idle(ELEN - 3);
    cycle(1, 8'hB0);
    idle(2);
    chk("R12 idle ready", statusReg[7:6], 2'b10);
    chk("R12 drained", eraseLeft, 0);
    idle(SLAT);
    chk("R12 no late suspend", statusReg[6], 0);

    // random mix
    begin
      logic [7:0] codes [9] = '{8'h20, 8'h40, 8'hB0, 8'hD0, 8'h70, 8'h50, 8'h98, 8'hB8, 8'hFF};
      void'($urandom(32'd1234));
      for (int i = 0; i < 4000; i++) begin
        int r = $urandom_range(0, 99);
        if (r < 8)       cycle(1, codes[$urandom_range(0, 8)]);
        else if (r < 10) cycle(1, 8'($urandom));
        else             cycle(0, 8'h00);
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule